// File: doc/BRIEF.md
# Modem Line Status Register

This block watches the four active-low modem handshake inputs of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them as one 8-bit status word. The upper nibble shows the present asserted state of each line. The lower nibble holds sticky change flags that record line activity since the status word was last read.

Each external input passes through a flop synchronizer before it is compared against the previously registered line state. A read strobe returns the current word, and the change flags clear at the edge that samples the strobe. An internal loopback switch replaces the external inputs with the port's own modem control bits. This lets software exercise the status path without a cable attached. A change-interrupt output tells the surrounding interrupt logic that a flag is pending.

Top module: `modem_status_reg`

## Requirements
- R1: Bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are set when the synchronized state of that line changes in either direction. Once set, they stay set until a read.
- R2: Bit 2 is set only when the ring input goes from low to high (bit 6 falls). A high-to-low ring transition leaves bit 2 unchanged.
- R3: Outside loopback, bits 4, 5, 6 and 7 show the inverted level of the clear-to-send, data-set-ready, ring and carrier inputs. An input change appears on the third rising clock edge after it is first sampled, because it passes two synchronizer flops.
- R4: In loopback, bits 4, 5, 6 and 7 follow `rts_i`, `dtr_i`, `out1_i` and `out2_i` at the next edge. The external line inputs then have no effect on any status bit.
- R5: Entering or leaving loopback counts as a line change. Every line whose shown state differs across the switch sets its change flag under the rules of R1 and R2.
- R6: When `rd_i` is high at an edge, bits 0 to 3 are cleared at that edge, while the data seen during that cycle is the value before clearing. A line event detected at the same edge still sets its flag.
- R7: `chg_irq_o` is high exactly when any of bits 0 to 3 is set.
- R8: During reset the whole status word and `chg_irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator line, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect line, active low, asynchronous |
| loop_en_i | input | 1 | Internal loopback enable |
| rts_i | input | 1 | Request-to-send control bit, shown as bit 4 in loopback |
| dtr_i | input | 1 | Data-terminal-ready control bit, shown as bit 5 in loopback |
| out1_i | input | 1 | User output 1, shown as bit 6 in loopback |
| out2_i | input | 1 | User output 2, shown as bit 7 in loopback |
| rd_i | input | 1 | Status read strobe |
| status_o | output | 8 | Status word: flags in bits 3:0, line states in bits 7:4 |
| chg_irq_o | output | 1 | Change interrupt, any flag pending |

## Verification
The hardest case to reach from the ports is a read strobe that lands on the same edge where a new line event is detected. Only then does the clear-before-set ordering of R6 show. The stimulus changes an input and then raises the read strobe exactly two falling edges later. This places the read on the edge where the synchronized change arrives. Long runs with random line toggles, random reads and occasional loopback switches repeat this and the loopback-switch events of R5 many more times. The behavioural model is compared against the outputs on every cycle.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       loop_en_i,
  input  logic       rts_i,
  input  logic       dtr_i,
  input  logic       out1_i,
  input  logic       out2_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       chg_irq_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] line_q, flag_q, line_now, delta, event_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign line_now = loop_en_i ? {out2_i, out1_i, dtr_i, rts_i} : ~sync_q[LAST];
  assign delta    = line_now ^ line_q;
  assign event_v  = {delta[3], line_q[2] & ~line_now[2], delta[1], delta[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      flag_q <= '0;
    end else begin
      line_q <= line_now;
      flag_q <= (rd_i ? 4'b0000 : flag_q) | event_v;
    end
  end

  assign status_o  = {line_q, flag_q};
  assign chg_irq_o = |flag_q;
endmodule

// File: rtl/modem_status_reg_chk.sv
module modem_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_i,
  input logic       loop_en_i,
  input logic       rts_i,
  input logic       dtr_i,
  input logic       out1_i,
  input logic       out2_i,
  input logic [7:0] status_o
);
  // R1
  cts_change_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o[4]) |-> status_o[0]);

  // R1
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0]));

  // R2
  ring_lead_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[6]) |-> !$rose(status_o[2]));

  // R4
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_i |=> status_o[7:4] == $past({out2_i, out1_i, dtr_i, rts_i}));
endmodule

bind modem_status_reg modem_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .loop_en_i(loop_en_i),
  .rts_i(rts_i), .dtr_i(dtr_i), .out1_i(out1_i), .out2_i(out2_i),
  .status_o(status_o)
);

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cts_n, dsr_n, ri_n, dcd_n, loop_en, rts, dtr, out1, out2, rd;
  logic [7:0] status;
  logic irq;

  modem_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n),
    .dcd_n_i(dcd_n), .loop_en_i(loop_en), .rts_i(rts), .dtr_i(dtr),
    .out1_i(out1), .out2_i(out2), .rd_i(rd), .status_o(status), .chg_irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: two-sample delay queue of raw line levels
  int hist[$];
  int m_state = 0;
  int m_flags = 0;
  int m_loop  = 0;

  always @(posedge clk) begin : model
    int raw_now, seen, cur, ev;
    raw_now = {28'd0, dcd_n, ri_n, dsr_n, cts_n};
    if (!rst_n) begin
      m_state = 0; m_flags = 0; m_loop = 0;
      hist = {15, 15};
    end else begin
      seen = hist[0];
      if (loop_en) cur = {28'd0, out2, out1, dtr, rts};
      else cur = (~seen) & 15;
      ev = 0;
      for (int b = 0; b < 4; b++) begin
        if (b == 2) begin
          if (((m_state >> 2) & 1) == 1 && ((cur >> 2) & 1) == 0) ev |= 4;
        end else if (((m_state ^ cur) >> b) & 1) ev |= (1 << b);
      end
      if (rd) m_flags = 0;
      m_flags |= ev;
      m_state = cur;
      m_loop = loop_en;
      void'(hist.pop_front());
      hist.push_back(raw_now);
    end
  end

  always @(negedge clk) begin : compare
    if (rst_n === 1'b1 && !done) begin
      for (int b = 0; b < 4; b++)
        chk(status[b] == ((m_flags >> b) & 1), (b == 2) ? "R2 flag" : "R1 flag",
            status[b], (m_flags >> b) & 1);
      chk(status[7:4] == m_state[3:0], m_loop ? "R4 line" : "R3 line",
          status[7:4], m_state);
      chk(irq == (m_flags != 0), "R7 irq", irq, m_flags != 0);
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  initial begin : stim
    rst_n = 1'b0;
    {cts_n, dsr_n, ri_n, dcd_n} = 4'hF;
    {loop_en, rts, dtr, out1, out2, rd} = '0;
    tick(3);
    // R8
    chk(status == 8'h00, "R8 status", status, 0);
    chk(irq == 1'b0, "R8 irq", irq, 0);
    rst_n = 1'b1;
    tick(4);

    // R3 latency: change visible after the third rising edge
    cts_n = 1'b0; tick(2);
    chk(status[4] == 1'b0, "R3 early", status[4], 0);
    tick(1);
    chk(status[4] == 1'b1, "R3 line", status[4], 1);
    chk(status[0] == 1'b1, "R1 cts flag", status[0], 1);
    clear_flags(); tick(2);

    // R2: leading edge of ring does not flag, trailing edge does
    ri_n = 1'b0; tick(4);
    chk(status[6] == 1'b1 && status[2] == 1'b0, "R2 lead", status, 8'h50);
    ri_n = 1'b1; tick(4);
    chk(status[2] == 1'b1, "R2 trail", status[2], 1);
    chk(irq == 1'b1, "R7 pending", irq, 1);
    clear_flags(); tick(1);
    chk(irq == 1'b0, "R7 cleared", irq, 0);

    // R5: entering loopback with a differing control bit
    cts_n = 1'b1; tick(4); clear_flags();
    dtr = 1'b1; loop_en = 1'b1; tick(1);
    chk(status[5] == 1'b1 && status[1] == 1'b1, "R5 enter", status, 8'h22);
    clear_flags();
    // R4: external lines ignored in loopback
    cts_n = 1'b0; dcd_n = 1'b0; tick(5);
    chk(status == 8'h20, "R4 ignore", status, 8'h20);
    // R5: leaving loopback
    loop_en = 1'b0; tick(1);
    chk(status[7:4] == 4'h9 && status[3:0] == 4'hB, "R5 leave", status, 8'h9B);
    clear_flags(); tick(3);

    // R6: read on the same edge that a new event is detected
    dsr_n = 1'b0; tick(4);
    cts_n = 1'b1; tick(2);
    rd = 1'b1; tick(1); rd = 1'b0;
    chk(status[0] == 1'b1, "R6 same-edge kept", status[0], 1);
    chk(status[1] == 1'b0, "R6 cleared", status[1], 0);
    tick(2);

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(5) == 0) begin
        case ($urandom_range(3))
          0: cts_n = ~cts_n;
          1: dsr_n = ~dsr_n;
          2: ri_n  = ~ri_n;
          default: dcd_n = ~dcd_n;
        endcase
      end
      if ($urandom_range(150) == 0) loop_en = ~loop_en;
      if ($urandom_range(7) == 0) {rts, dtr, out1, out2} = 4'($urandom);
      rd = ($urandom_range(4) == 0);
      tick(1);
    end
    rd = 1'b0;
    tick(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule